// File: doc/BRIEF.md
# Square-Wave Bridge Commutator with Ignition Gating

This block turns a half-period event from a slow bridge oscillator into the four gate commands of a full bridge that feeds a lamp with a low-frequency square wave. The two diagonals of the bridge take turns conducting. Every change of diagonal goes through a dead-time, a programmable number of clock cycles in which all four gates are off. The bridge starts when the run enable rises and shuts down when it falls. The run enable is the only path to a shutdown, whether the cause is a fault or supply undervoltage.

The block also generates the enable for the ignition pulse circuit. A slow tick marks the ignition time base. The tick count forms a repeating schedule with a short on window followed by a longer off window. The schedule starts when ignition is requested. Once the lamp reports that it has struck, the schedule finishes any on window already in progress and then halts. The ignition output is further gated by the bridge, so it can be high only while a diagonal is actually conducting and never during dead-time. This keeps the ignition pulses from landing on floating half-bridge midpoints.

Top module: `hbc_commutator`

## Requirements
- R1: While reset is asserted, and after reset until the run enable rises, all four gate outputs and the ignition output are low.
- R2: When the run enable is first sampled high, the gates stay all low for DEAD_CYC cycles. After that, diagonal A (low gate of leg 1 and high gate of leg 2) turns on.
- R3: A half-period tick sampled while a diagonal is on turns all gates off for DEAD_CYC cycles, starting the next cycle. After that, the other diagonal turns on, so diagonals A and B alternate (diagonal B is the low gate of leg 2 with the high gate of leg 1). Diagonal A is never followed directly by diagonal B.
- R4: A half-period tick sampled during dead-time, or in the same cycle that the run enable is first seen, has no effect on the order or the timing of the gates.
- R5: One cycle after the run enable is sampled low, all gates and the ignition output are low. When the run enable rises again, the sequence restarts as in R2 with diagonal A.
- R6: The high and low gate of the same leg are never both high.
- R7: The ignition schedule starts, with its tick count at 0, on the first cycle in which both the ignition request and the run enable are sampled high. Each slow tick advances the count modulo IGN_PERIOD. The schedule window is open while the count is below IGN_ON.
- R8: The ignition output is high exactly when the schedule window is open and a diagonal is on. It is low during every dead-time.
- R9: After a lamp-lit indication, an open window runs on until the count reaches IGN_ON. The schedule then halts, and the ignition output stays low for any number of further ticks until the request or the run enable is removed.
- R10: One cycle after the ignition request is sampled low, the ignition output is low and the schedule is cleared. A new request restarts it at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Bridge run enable; low means fault or undervoltage shutdown |
| half_tick | input | 1 | One-cycle pulse at each oscillator half period |
| ign_tick | input | 1 | One-cycle pulse of the slow ignition time base |
| ign_req | input | 1 | Ignition mode request |
| lamp_lit | input | 1 | Lamp has struck (pulse or level) |
| bridge_hi1 | output | 1 | High-side gate, leg 1 |
| bridge_lo1 | output | 1 | Low-side gate, leg 1 |
| bridge_hi2 | output | 1 | High-side gate, leg 2 |
| bridge_lo2 | output | 1 | Low-side gate, leg 2 |
| ign_drive | output | 1 | Gated ignition enable |

## Verification
The hardest situation to reach from the ports is a lamp-lit indication that arrives in the middle of an open ignition window. To check it, the window must be seen to run on to its full length, and the output must then stay dark for more than one whole schedule period, which proves the timer stopped and did not merely wrap. The stimulus first walks the tick count through a complete period so that the wrap itself is observed. It raises the lamp-lit pulse at count 0 and then issues well over IGN_PERIOD further ticks. A second hard case is a dead-time that falls inside an open window. The bench forces it by issuing a half-period tick while the ignition output is high. A long randomized phase then mixes all inputs against a behavioural model that is compared on every clock.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  // Which diagonal of the bridge is selected to conduct next / now.
  typedef enum logic {
    DIAG_A = 1'b0,   // leg-1 low gate with leg-2 high gate
    DIAG_B = 1'b1    // leg-2 low gate with leg-1 high gate
  } diag_e;

  typedef struct packed {
    logic hi1;
    logic lo1;
    logic hi2;
    logic lo2;
  } gates_t;

  // Gate pattern for a diagonal; nothing is driven unless conducting.
  function automatic gates_t gates_for(diag_e d, logic conduct);
    gates_t g;
    g = '0;
    if (conduct) begin
      if (d == DIAG_A) begin
        g.lo1 = 1'b1;
        g.hi2 = 1'b1;
      end else begin
        g.lo2 = 1'b1;
        g.hi1 = 1'b1;
      end
    end
    return g;
  endfunction

  function automatic diag_e flip_diag(diag_e d);
    return (d == DIAG_A) ? DIAG_B : DIAG_A;
  endfunction

  // Ignition schedule arithmetic.
  function automatic logic window_open(int unsigned count, int unsigned on_len);
    return count < on_len;
  endfunction

  function automatic int unsigned tick_advance(int unsigned count, int unsigned period);
    return (count == period - 1) ? 0 : count + 1;
  endfunction

endpackage

// File: rtl/hbc_phase_seq.sv
module hbc_phase_seq
  import hbc_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_en,
  input  logic  half_tick,
  output diag_e diag,
  output logic  pair_on,
  output logic  in_dead,
  output logic  tick_taken
);
  localparam int unsigned DW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [DW-1:0] DEAD_LOAD = DW'(DEAD_CYC - 1);

  logic          started_q;
  logic          dead_q;
  logic          on_q;
  logic [DW-1:0] dcnt_q;
  diag_e         diag_q;

  logic          dead_done;

  assign dead_done  = dead_q && (dcnt_q == '0);
  assign tick_taken = run_en && started_q && on_q && half_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      dead_q    <= 1'b0;
      on_q      <= 1'b0;
      dcnt_q    <= '0;
      diag_q    <= DIAG_A;
    end else if (!run_en) begin
      started_q <= 1'b0;
      dead_q    <= 1'b0;
      on_q      <= 1'b0;
      dcnt_q    <= '0;
      diag_q    <= DIAG_A;
    end else if (!started_q) begin
      started_q <= 1'b1;
      dead_q    <= 1'b1;
      on_q      <= 1'b0;
      dcnt_q    <= DEAD_LOAD;
      diag_q    <= DIAG_A;
    end else if (dead_q) begin
      if (dead_done) begin
        dead_q <= 1'b0;
        on_q   <= 1'b1;
      end else begin
        dcnt_q <= dcnt_q - 1'b1;
      end
    end else if (tick_taken) begin
      on_q   <= 1'b0;
      dead_q <= 1'b1;
      dcnt_q <= DEAD_LOAD;
      diag_q <= flip_diag(diag_q);
    end
  end

  assign diag    = diag_q;
  assign pair_on = on_q;
  assign in_dead = dead_q;

endmodule

// File: rtl/hbc_ign_timer.sv
module hbc_ign_timer
  import hbc_pkg::*;
#(
  parameter int unsigned IGN_PERIOD = 128,
  parameter int unsigned IGN_ON     = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic ign_req,
  input  logic ign_tick,
  input  logic lamp_lit,
  output logic window,
  output logic timer_run,
  output logic timer_done
);
  localparam int unsigned CW = (IGN_PERIOD > 1) ? $clog2(IGN_PERIOD) : 1;

  logic          run_q;
  logic          done_q;
  logic          lit_q;
  logic [CW-1:0] cnt_q;

  logic          cnt_in_window;
  logic          stop_now;

  assign cnt_in_window = window_open(32'(cnt_q), IGN_ON);
  assign stop_now      = run_q && (lit_q || lamp_lit) && !cnt_in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      lit_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (!run_en || !ign_req) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      lit_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (!run_q && !done_q) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (stop_now) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        if (lamp_lit) lit_q <= 1'b1;
        if (ign_tick) cnt_q <= CW'(tick_advance(32'(cnt_q), IGN_PERIOD));
      end
    end
  end

  assign window     = run_q && cnt_in_window;
  assign timer_run  = run_q;
  assign timer_done = done_q;

endmodule

// File: rtl/hbc_ign_gate.sv
module hbc_ign_gate (
  input  logic window,
  input  logic pair_on,
  input  logic in_dead,
  output logic ign
);
  // Ignition may only fire onto a biased bridge midpoint.
  assign ign = window && pair_on && !in_dead;
endmodule

// File: rtl/hbc_commutator.sv
module hbc_commutator
  import hbc_pkg::*;
#(
  parameter int unsigned DEAD_CYC   = 4,
  parameter int unsigned IGN_PERIOD = 128,
  parameter int unsigned IGN_ON     = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic half_tick,
  input  logic ign_tick,
  input  logic ign_req,
  input  logic lamp_lit,
  output logic bridge_hi1,
  output logic bridge_lo1,
  output logic bridge_hi2,
  output logic bridge_lo2,
  output logic ign_drive
);
  diag_e  diag;
  logic   pair_on;
  logic   dead_now;
  logic   tick_taken;
  logic   window;
  logic   timer_run;
  logic   timer_done;
  gates_t gates;

  hbc_phase_seq #(.DEAD_CYC(DEAD_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .half_tick  (half_tick),
    .diag       (diag),
    .pair_on    (pair_on),
    .in_dead    (dead_now),
    .tick_taken (tick_taken)
  );

  hbc_ign_timer #(.IGN_PERIOD(IGN_PERIOD), .IGN_ON(IGN_ON)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .ign_req    (ign_req),
    .ign_tick   (ign_tick),
    .lamp_lit   (lamp_lit),
    .window     (window),
    .timer_run  (timer_run),
    .timer_done (timer_done)
  );

  hbc_ign_gate u_gate (
    .window  (window),
    .pair_on (pair_on),
    .in_dead (dead_now),
    .ign     (ign_drive)
  );

  assign gates      = gates_for(diag, pair_on);
  assign bridge_hi1 = gates.hi1;
  assign bridge_lo1 = gates.lo1;
  assign bridge_hi2 = gates.hi2;
  assign bridge_lo2 = gates.lo2;

endmodule

// File: rtl/hbc_checker.sv
module hbc_checker (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic hi1,
  input logic lo1,
  input logic hi2,
  input logic lo2,
  input logic ign,
  input logic in_dead,
  input logic timer_done
);
  logic diag_a_on;
  logic diag_b_on;
  logic any_gate;

  assign diag_a_on = lo1 && hi2;
  assign diag_b_on = lo2 && hi1;
  assign any_gate  = hi1 || lo1 || hi2 || lo2;

  assert_leg_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi1 && lo1) && !(hi2 && lo2));

  assert_no_direct_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    diag_a_on |=> !diag_b_on);

  assert_off_after_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !any_gate && !ign);

  assert_ign_needs_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ign |-> (diag_a_on || diag_b_on));

  assert_dead_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_dead |-> !any_gate && !ign);

  assert_halted_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timer_done |-> !ign);

endmodule

bind hbc_commutator hbc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .hi1        (bridge_hi1),
  .lo1        (bridge_lo1),
  .hi2        (bridge_hi2),
  .lo2        (bridge_lo2),
  .ign        (ign_drive),
  .in_dead    (dead_now),
  .timer_done (timer_done)
);

// File: tb/hbc_commutator_test.sv
module hbc_commutator_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD   = 4;
  localparam int PER    = 128;
  localparam int ON_LEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic half_tick = 1'b0;
  logic ign_tick = 1'b0;
  logic ign_req = 1'b0;
  logic lamp_lit = 1'b0;
  logic hi1, lo1, hi2, lo2, ign;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbc_commutator #(.DEAD_CYC(DEAD), .IGN_PERIOD(PER), .IGN_ON(ON_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .half_tick(half_tick),
    .ign_tick(ign_tick), .ign_req(ign_req), .lamp_lit(lamp_lit),
    .bridge_hi1(hi1), .bridge_lo1(lo1), .bridge_hi2(hi2), .bridge_lo2(lo2),
    .ign_drive(ign)
  );

  // Behavioural reference, written from the requirements.
  int  b_mode;      // 0 idle, 1 dead-time, 2 conducting
  int  b_left;      // dead cycles still to show after this one
  int  b_side;      // 0 = diagonal A, 1 = diagonal B
  int  t_state;     // 0 cleared, 1 counting, 2 halted
  int  t_count;
  bit  t_lit;

  always @(posedge clk) begin
    if (!rst_n || !run_en) begin
      b_mode = 0; b_left = 0; b_side = 0;
    end else if (b_mode == 0) begin
      b_mode = 1; b_left = DEAD - 1; b_side = 0;
    end else if (b_mode == 1) begin
      if (b_left == 0) b_mode = 2; else b_left = b_left - 1;
    end else if (half_tick) begin
      b_mode = 1; b_left = DEAD - 1; b_side = 1 - b_side;
    end

    if (!rst_n || !run_en || !ign_req) begin
      t_state = 0; t_count = 0; t_lit = 0;
    end else if (t_state == 0) begin
      t_state = 1; t_count = 0;
    end else if (t_state == 1) begin
      if ((t_lit || lamp_lit) && t_count >= ON_LEN) begin
        t_state = 2; t_count = 0;
      end else begin
        if (lamp_lit) t_lit = 1;
        if (ign_tick) t_count = (t_count + 1) % PER;
      end
    end
  end

  function automatic logic [4:0] model_out();
    logic [4:0] v;  // {hi1, lo1, hi2, lo2, ign}
    v = '0;
    if (b_mode == 2) begin
      if (b_side == 0) begin v[3] = 1; v[2] = 1; end
      else begin v[4] = 1; v[1] = 1; end
      if (t_state == 1 && t_count < ON_LEN) v[0] = 1;
    end
    return v;
  endfunction

  task automatic compare_model();
    logic [4:0] got, exp_v;
    got = {hi1, lo1, hi2, lo2, ign};
    exp_v = model_out();
    checks++;
    if (got[4:1] !== exp_v[4:1]) begin
      errors++;
      $display("FAIL R3 gate pattern t=%0t actual=%b expected=%b", $time, got[4:1], exp_v[4:1]);
    end else if (got[0] !== exp_v[0]) begin
      errors++;
      $display("FAIL R8 ignition output t=%0t actual=%b expected=%b", $time, got[0], exp_v[0]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_model();
  endtask

  // expected pattern {hi1, lo1, hi2, lo2, ign}
  task automatic expect_pins(string tag, logic [4:0] exp_v);
    checks++;
    if ({hi1, lo1, hi2, lo2, ign} !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, {hi1, lo1, hi2, lo2, ign}, exp_v);
    end
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      ign_tick = 1; step(); ign_tick = 0; step();
    end
  endtask

  localparam logic [4:0] DARK  = 5'b00000;
  localparam logic [4:0] PAIRA = 5'b01100;
  localparam logic [4:0] PAIRB = 5'b10010;

  initial begin
    repeat (3) @(negedge clk);
    expect_pins("R1 in reset", DARK);
    rst_n = 1;
    half_tick = 1; step(); half_tick = 0;
    expect_pins("R1 idle after reset", DARK);

    // R2 start, with a half tick on the start cycle (R4)
    run_en = 1; half_tick = 1; step(); half_tick = 0;
    expect_pins("R2 first dead cycle", DARK);
    for (int i = 1; i < DEAD; i++) begin step(); expect_pins("R2 initial dead-time", DARK); end
    step(); expect_pins("R2 first diagonal A", PAIRA);
    step(); step(); expect_pins("R2 diagonal A holds", PAIRA);

    // R3 commutation with an extra tick inside dead-time (R4)
    half_tick = 1; step(); half_tick = 0;
    expect_pins("R3 dead after tick", DARK);
    half_tick = 1; step(); half_tick = 0;
    expect_pins("R4 tick in dead ignored", DARK);
    for (int i = 2; i < DEAD; i++) begin step(); expect_pins("R4 dead length kept", DARK); end
    step(); expect_pins("R3 diagonal B", PAIRB);

    // R7 ignition schedule
    ign_req = 1; step();
    expect_pins("R7 window opens on request", PAIRB | 5'b00001);
    tick_n(10);
    expect_pins("R7 window still open", PAIRB | 5'b00001);
    half_tick = 1; step(); half_tick = 0;
    expect_pins("R8 ignition dark in dead-time", DARK);
    for (int i = 1; i < DEAD; i++) step();
    step(); expect_pins("R8 ignition back on new pair", PAIRA | 5'b00001);
    tick_n(ON_LEN - 11);
    expect_pins("R7 last open tick", PAIRA | 5'b00001);
    tick_n(1);
    expect_pins("R7 window closes", PAIRA);
    tick_n(PER - ON_LEN - 1);
    expect_pins("R7 closed until wrap", PAIRA);
    tick_n(1);
    expect_pins("R7 window reopens after period", PAIRA | 5'b00001);

    // R9 lamp lit inside open window
    lamp_lit = 1; step(); lamp_lit = 0;
    expect_pins("R9 window continues after lit", PAIRA | 5'b00001);
    tick_n(ON_LEN - 1);
    expect_pins("R9 window runs to full length", PAIRA | 5'b00001);
    tick_n(1);
    expect_pins("R9 window ends", PAIRA);
    tick_n(PER + 20);
    expect_pins("R9 halted past a period", PAIRA);

    // R10 request removal and restart
    ign_req = 0; step();
    expect_pins("R10 request low", PAIRA);
    ign_req = 1; step();
    expect_pins("R10 restart at count 0", PAIRA | 5'b00001);
    ign_req = 0; step();
    expect_pins("R10 cleared mid-window", PAIRA);

    // R5 shutdown and restart
    ign_req = 1; step();
    run_en = 0; step();
    expect_pins("R5 all dark after disable", DARK);
    step(); expect_pins("R5 stays dark", DARK);
    run_en = 1;
    for (int i = 0; i < DEAD; i++) begin step(); expect_pins("R5 restart dead-time", DARK); end
    step(); expect_pins("R5 restart on diagonal A", PAIRA | 5'b00001);

    // randomized mix, compared to the model every cycle (R6 via checker)
    for (int c = 0; c < 6000; c++) begin
      half_tick = ($urandom_range(0, 15) == 0);
      ign_tick  = ($urandom_range(0, 2) == 0);
      lamp_lit  = ($urandom_range(0, 400) == 0);
      if ($urandom_range(0, 700) == 0) ign_req = ~ign_req;
      run_en    = ($urandom_range(0, 1500) != 0);
      step();
      if (hi1 && lo1 || hi2 && lo2) begin
        errors++;
        $display("FAIL R6 leg shoot-through actual=%b expected no leg with both gates", {hi1, lo1, hi2, lo2});
      end
      checks++;
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule